// File: doc/BRIEF.md
# Sixteen-Point Matrix-Form DFT Engine

This block takes frames of sixteen complex fixed-point samples and returns their sixteen-point discrete Fourier transform, without scaling. The samples of a frame are treated as a 4x4 array: sample x[4a+c] sits at row a, column c. A four-point butterfly product turns each column into four partial spectra. A column of four complex multipliers then weights each partial spectrum with a coefficient taken from a constant table. A second four-point butterfly product, applied along the rows, completes the transform. The butterfly coefficients are only +1, -1, +j and -j, so both products need adders alone. All the true multiplication is done in the four multipliers between the two products.

Samples arrive on a valid/ready stream, one per cycle at most. After the sixteenth sample of a frame is taken, the engine stops accepting input. It then runs the four columns through the first product and the multipliers, one column per cycle. While it emits the sixteen bins in natural order, it accepts the next frame, so a new frame can load while the previous one drains.

Top module: `dft16_matrix_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, in_ready is 1 and out_valid is 0.
- R2: A sample is taken only on a rising edge where in_valid and in_ready are both 1. The k-th sample taken within a frame (k = 0..15) is x[k], and idle cycles between samples change nothing.
- R3: After the edge that takes the sixteenth sample, in_ready is 0 for exactly five cycles and then returns to 1.
- R4: For bin k, the output pair (out_re, out_im) equals the sum over n of x[n]*exp(-j*2*pi*k*n/16), with no scaling. Each component is within 3 LSB of the exact value rounded to an integer. Each output component is DW+5 bits wide.
- R5: The sixteen bins of a frame appear on sixteen consecutive cycles with out_valid high, in the order k = 0, 1, ..., 15. out_valid is low on the cycle after the last bin.
- R6: A weight whose exponent k1*c is zero passes data through untouched. As a result, bins 0, 4, 8 and 12 are bit-exact.
- R7: While in_ready is 0, in_valid and the sample inputs have no effect on any frame.
- R8: Full-scale inputs produce no wrap-around. This includes every component at -2^(DW-1) and a tone at the largest amplitude.
- R9: The first bin of a frame is presented with out_valid on the sixth rising edge after the edge that took the frame's sixteenth sample.
- R10: A frame may be loaded while the previous frame's bins drain. Both frames come out correct, and the second keeps the latency of R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | The engine can take a sample |
| in_re | input | DW | Real part of the sample, two's complement |
| in_im | input | DW | Imaginary part of the sample, two's complement |
| out_valid | output | 1 | out_re/out_im hold a bin |
| out_re | output | DW+5 | Real part of the bin |
| out_im | output | DW+5 | Imaginary part of the bin |

## Verification
The bench builds the engine with DW = 12, CW = 16 and the unity-weight pass-through enabled. Twelve-bit samples let full-scale frames drive bin magnitudes up to 16*2048, which tests the DW+5 output range at its corners, both for the most negative code on every input and for a maximal tone. A sixteen-bit coefficient keeps the total rounding error of three weighted terms below the 3 LSB bound. With the pass-through enabled, the bins with index divisible by four can be checked for exact equality rather than within a tolerance.

// File: rtl/dft16_pkg.sv
package dft16_pkg;

   localparam int RADIX = 4;
   localparam int NPT   = RADIX * RADIX;
   localparam int IDXW  = $clog2(NPT);
   localparam int CIW   = $clog2(RADIX);

   // Rounded fixed-point value of cos or sin of 2*pi*e/NPT in Q1.(cw-1),
   // limited to the symmetric range so +1.0 maps to the largest code.
   function automatic int coef_val(input int e, input int cw, input bit want_sin);
      real ang;
      real full;
      real v;
      int  r;
      int  lim;
      ang  = 2.0 * 3.14159265358979323846 * real'(e) / real'(NPT);
      full = 2.0 ** (cw - 1);
      v    = want_sin ? $sin(ang) * full : $cos(ang) * full;
      r    = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
      lim  = (1 << (cw - 1)) - 1;
      if (r > lim)  r = lim;
      if (r < -lim) r = -lim;
      return r;
   endfunction

endpackage

// File: rtl/dft16_radix4.sv
module dft16_radix4
   import dft16_pkg::*;
#(
   parameter int IW = 12,
   parameter int OW = 15
) (
   input  logic signed [IW-1:0] x_re [RADIX],
   input  logic signed [IW-1:0] x_im [RADIX],
   output logic signed [OW-1:0] y_re [RADIX],
   output logic signed [OW-1:0] y_im [RADIX]
);

   if (OW < IW + 2) begin : g_bad_width
      $error("dft16_radix4: OW must be at least IW+2");
   end
   if (RADIX != 4) begin : g_bad_radix
      $error("dft16_radix4: only radix 4 is supported");
   end

   logic signed [OW-1:0] ar [RADIX];
   logic signed [OW-1:0] ai [RADIX];

   always_comb begin
      for (int i = 0; i < RADIX; i++) begin
         ar[i] = OW'(x_re[i]);
         ai[i] = OW'(x_im[i]);
      end
   end

   // y[k] = sum_a x[a] * (-j)^(a*k)
   always_comb begin
      y_re[0] = ar[0] + ar[1] + ar[2] + ar[3];
      y_im[0] = ai[0] + ai[1] + ai[2] + ai[3];
      y_re[1] = ar[0] + ai[1] - ar[2] - ai[3];
      y_im[1] = ai[0] - ar[1] - ai[2] + ar[3];
      y_re[2] = ar[0] - ar[1] + ar[2] - ar[3];
      y_im[2] = ai[0] - ai[1] + ai[2] - ai[3];
      y_re[3] = ar[0] - ai[1] - ar[2] + ai[3];
      y_im[3] = ai[0] + ar[1] - ai[2] - ar[3];
   end

endmodule

// File: rtl/dft16_coef_rom.sv
module dft16_coef_rom
   import dft16_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic [IDXW-1:0]        exp_i,
   output logic signed [CW-1:0]   cos_o,
   output logic signed [CW-1:0]   sin_o
);

   if (CW < 4 || CW > 24) begin : g_bad_cw
      $error("dft16_coef_rom: CW out of range");
   end

   logic signed [CW-1:0] cos_tab [NPT];
   logic signed [CW-1:0] sin_tab [NPT];

   for (genvar e = 0; e < NPT; e++) begin : g_ent
      localparam int CV = coef_val(e, CW, 1'b0);
      localparam int SV = coef_val(e, CW, 1'b1);
      assign cos_tab[e] = CV[CW-1:0];
      assign sin_tab[e] = SV[CW-1:0];
   end

   assign cos_o = cos_tab[exp_i];
   assign sin_o = sin_tab[exp_i];

endmodule

// File: rtl/dft16_cmul.sv
module dft16_cmul
   import dft16_pkg::*;
#(
   parameter int IW           = 15,
   parameter int CW           = 16,
   parameter bit BYPASS_UNITY = 1'b1
) (
   input  logic [IDXW-1:0]        exp_i,
   input  logic signed [IW-1:0]   a_re,
   input  logic signed [IW-1:0]   a_im,
   output logic signed [IW-1:0]   p_re,
   output logic signed [IW-1:0]   p_im
);

   localparam int PW = IW + CW + 1;
   localparam logic signed [PW-1:0] RND  = {{(PW-CW+1){1'b0}}, 1'b1, {(CW-2){1'b0}}};
   localparam logic signed [PW-1:0] MAXV = {{(PW-IW+1){1'b0}}, {(IW-1){1'b1}}};
   localparam logic signed [PW-1:0] MINV = {{(PW-IW+1){1'b1}}, {(IW-1){1'b0}}};

   logic signed [CW-1:0] c_q;
   logic signed [CW-1:0] s_q;

   dft16_coef_rom #(.CW(CW)) u_rom (
      .exp_i (exp_i),
      .cos_o (c_q),
      .sin_o (s_q)
   );

   logic signed [PW-1:0] ar_x, ai_x, c_x, s_x;
   logic signed [PW-1:0] pr, pi;
   logic signed [PW-1:0] rr, ri;
   logic signed [IW-1:0] mr, mi;

   always_comb begin
      ar_x = PW'(a_re);
      ai_x = PW'(a_im);
      c_x  = PW'(c_q);
      s_x  = PW'(s_q);
      // (a_re + j a_im) * (c - j s)
      pr   = ar_x * c_x + ai_x * s_x;
      pi   = ai_x * c_x - ar_x * s_x;
      rr   = (pr + RND) >>> (CW - 1);
      ri   = (pi + RND) >>> (CW - 1);
      if (rr > MAXV)      mr = MAXV[IW-1:0];
      else if (rr < MINV) mr = MINV[IW-1:0];
      else                mr = rr[IW-1:0];
      if (ri > MAXV)      mi = MAXV[IW-1:0];
      else if (ri < MINV) mi = MINV[IW-1:0];
      else                mi = ri[IW-1:0];
   end

   if (BYPASS_UNITY) begin : g_bypass
      assign p_re = (exp_i == '0) ? a_re : mr;
      assign p_im = (exp_i == '0) ? a_im : mi;
   end else begin : g_always_mul
      assign p_re = mr;
      assign p_im = mi;
   end

endmodule

// File: rtl/dft16_matrix_engine.sv
module dft16_matrix_engine
   import dft16_pkg::*;
#(
   parameter int DW           = 12,
   parameter int CW           = 16,
   parameter bit BYPASS_UNITY = 1'b1,
   localparam int OW          = DW + 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   output logic                 out_valid,
   output logic signed [OW-1:0] out_re,
   output logic signed [OW-1:0] out_im
);

   localparam int S1W = DW + 3;

   if (DW < 4 || DW > 24) begin : g_bad_dw
      $error("dft16_matrix_engine: DW out of range");
   end

   // ---------------- input frame store ----------------
   logic signed [DW-1:0] xr_q [NPT];
   logic signed [DW-1:0] xi_q [NPT];
   logic [IDXW-1:0]      ld_cnt;
   logic                 x_full;
   logic                 take;

   assign in_ready = !x_full;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (take) begin
         xr_q[ld_cnt] <= in_re;
         xi_q[ld_cnt] <= in_im;
      end
   end

   // ---------------- sequencing ----------------
   logic            col_act;
   logic [CIW-1:0]  col_idx;
   logic            drn_act;
   logic [IDXW-1:0] drn_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_cnt  <= '0;
         x_full  <= 1'b0;
         col_act <= 1'b0;
         col_idx <= '0;
         drn_act <= 1'b0;
         drn_idx <= '0;
      end else begin
         if (take) begin
            ld_cnt <= ld_cnt + 1'b1;
            if (ld_cnt == IDXW'(NPT - 1)) x_full <= 1'b1;
         end
         if (drn_act) begin
            drn_idx <= drn_idx + 1'b1;
            if (drn_idx == IDXW'(NPT - 1)) drn_act <= 1'b0;
         end
         if (x_full && !col_act && !drn_act) begin
            col_act <= 1'b1;
            col_idx <= '0;
         end else if (col_act) begin
            col_idx <= col_idx + 1'b1;
            if (col_idx == CIW'(RADIX - 1)) begin
               col_act <= 1'b0;
               x_full  <= 1'b0;
               drn_act <= 1'b1;
               drn_idx <= '0;
            end
         end
      end
   end

   // ---------------- first product + weight column ----------------
   logic signed [DW-1:0]  s1_xr [RADIX];
   logic signed [DW-1:0]  s1_xi [RADIX];
   logic signed [S1W-1:0] s1_yr [RADIX];
   logic signed [S1W-1:0] s1_yi [RADIX];
   logic signed [S1W-1:0] tw_re [RADIX];
   logic signed [S1W-1:0] tw_im [RADIX];

   for (genvar a = 0; a < RADIX; a++) begin : g_colsel
      assign s1_xr[a] = xr_q[{CIW'(a), col_idx}];
      assign s1_xi[a] = xi_q[{CIW'(a), col_idx}];
   end

   dft16_radix4 #(.IW(DW), .OW(S1W)) u_first (
      .x_re (s1_xr),
      .x_im (s1_xi),
      .y_re (s1_yr),
      .y_im (s1_yi)
   );

   for (genvar k = 0; k < RADIX; k++) begin : g_mul
      logic [IDXW-1:0] wexp;
      assign wexp = IDXW'(k) * {{(IDXW-CIW){1'b0}}, col_idx};
      dft16_cmul #(.IW(S1W), .CW(CW), .BYPASS_UNITY(BYPASS_UNITY)) u_cmul (
         .exp_i (wexp),
         .a_re  (s1_yr[k]),
         .a_im  (s1_yi[k]),
         .p_re  (tw_re[k]),
         .p_im  (tw_im[k])
      );
   end

   // weighted partial spectra, index {k1, c}
   logic signed [S1W-1:0] yr_q [NPT];
   logic signed [S1W-1:0] yi_q [NPT];

   always_ff @(posedge clk) begin
      if (col_act) begin
         for (int k = 0; k < RADIX; k++) begin
            yr_q[{CIW'(k), col_idx}] <= tw_re[k];
            yi_q[{CIW'(k), col_idx}] <= tw_im[k];
         end
      end
   end

   // ---------------- second product, one bin per cycle ----------------
   logic signed [S1W-1:0] s2_xr [RADIX];
   logic signed [S1W-1:0] s2_xi [RADIX];
   logic signed [OW-1:0]  s2_zr [RADIX];
   logic signed [OW-1:0]  s2_zi [RADIX];

   for (genvar c = 0; c < RADIX; c++) begin : g_rowsel
      assign s2_xr[c] = yr_q[{drn_idx[CIW-1:0], CIW'(c)}];
      assign s2_xi[c] = yi_q[{drn_idx[CIW-1:0], CIW'(c)}];
   end

   dft16_radix4 #(.IW(S1W), .OW(OW)) u_second (
      .x_re (s2_xr),
      .x_im (s2_xi),
      .y_re (s2_zr),
      .y_im (s2_zi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= drn_act;
   end

   always_ff @(posedge clk) begin
      if (drn_act) begin
         out_re <= s2_zr[drn_idx[IDXW-1:CIW]];
         out_im <= s2_zi[drn_idx[IDXW-1:CIW]];
      end
   end

endmodule

// File: rtl/dft16_matrix_engine_chk.sv
module dft16_matrix_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic out_valid
);

   logic [3:0] acc_cnt;
   logic [4:0] ov_run;
   logic [4:0] lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_cnt <= '0;
         ov_run  <= '0;
         lat     <= 5'd31;
      end else begin
         if (in_valid && in_ready) acc_cnt <= acc_cnt + 1'b1;
         if (out_valid) ov_run <= (ov_run == 5'd31) ? ov_run : ov_run + 1'b1;
         else           ov_run <= '0;
         if (in_valid && in_ready && acc_cnt == 4'd15) lat <= '0;
         else if (lat != 5'd31)                      lat <= lat + 1'b1;
      end
   end

   // R1: idle state right after reset release
   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (in_ready && !out_valid));

   // R3: input closes after the sixteenth sample
   p_busy_after_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && acc_cnt == 4'd15) |=> !in_ready);

   // R3: input is open again by the time bins start
   p_open_at_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> in_ready);

   // R5: bins come as bursts of exactly sixteen
   p_burst_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> (ov_run == 5'd16));

   // R9: first bin six edges after the frame is complete
   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (lat == 5'd6));

endmodule

bind dft16_matrix_engine dft16_matrix_engine_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid)
);

// File: tb/tb_dft16_matrix_engine.sv
module tb_dft16_matrix_engine;

   localparam int DW = 12;
   localparam int CW = 16;
   localparam int OW = DW + 5;
   localparam int TOL = 3;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic                 in_ready;
   logic signed [DW-1:0] in_re = '0;
   logic signed [DW-1:0] in_im = '0;
   logic                 out_valid;
   logic signed [OW-1:0] out_re;
   logic signed [OW-1:0] out_im;

   dft16_matrix_engine #(.DW(DW), .CW(CW), .BYPASS_UNITY(1'b1)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_re     (in_re),
      .in_im     (in_im),
      .out_valid (out_valid),
      .out_re    (out_re),
      .out_im    (out_im)
   );

   always #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_run  = 0;
   int n_fail = 0;
   int seed   = 12345;

   int fa_re [16], fa_im [16], fb_re [16], fb_im [16];
   int ya_re [16], ya_im [16], yb_re [16], yb_im [16];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int rnd(input real v);
      return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
   endfunction

   function automatic int next_rand();
      seed = seed * 1103515245 + 12345;
      return ((seed >>> 12) & 32'hFFF) - 2048;
   endfunction

   task automatic fill_random(output int r [16], output int i [16]);
      for (int n = 0; n < 16; n++) begin
         r[n] = next_rand();
         i[n] = next_rand();
      end
   endtask

   // Drive one frame; returns cyc seen at the negedge before the last taking edge.
   task automatic send_frame(input int r [16], input int i [16], input bit gaps,
                             output int acc_cyc);
      int  n = 0;
      bit  idled = 1'b0;
      while (n < 16) begin
         @(negedge clk);
         if (gaps && (n % 2 == 1) && !idled) begin
            in_valid = 1'b0;
            idled    = 1'b1;
         end else begin
            in_valid = 1'b1;
            in_re    = DW'(r[n]);
            in_im    = DW'(i[n]);
            if (in_ready) begin
               acc_cyc = cyc;
               n++;
               idled = 1'b0;
            end
         end
      end
   endtask

   // Gather 16 bins; checks they are back to back (R5).
   task automatic collect(output int r [16], output int i [16], output int first_cyc);
      do @(negedge clk); while (!out_valid);
      first_cyc = cyc;
      r[0] = out_re;
      i[0] = out_im;
      for (int b = 1; b < 16; b++) begin
         @(negedge clk);
         chk(out_valid == 1'b1, "R5", "out_valid during burst", int'(out_valid), 1);
         r[b] = out_re;
         i[b] = out_im;
      end
      @(negedge clk);
      chk(out_valid == 1'b0, "R5", "out_valid after last bin", int'(out_valid), 0);
   endtask

   // Compare against a real-valued transform (R4), exact for bins 0,4,8,12 (R6).
   task automatic check_bins(input int xr [16], input int xi [16],
                             input int yr [16], input int yi [16], input string req);
      for (int k = 0; k < 16; k++) begin
         real sr = 0.0, si = 0.0;
         int  er, ei;
         for (int n = 0; n < 16; n++) begin
            real th = -2.0 * 3.14159265358979323846 * real'(k * n) / 16.0;
            sr += real'(xr[n]) * $cos(th) - real'(xi[n]) * $sin(th);
            si += real'(xr[n]) * $sin(th) + real'(xi[n]) * $cos(th);
         end
         er = rnd(sr);
         ei = rnd(si);
         if (k % 4 == 0) begin
            chk(yr[k] == er, "R6", $sformatf("%s exact bin %0d re", req, k), yr[k], er);
            chk(yi[k] == ei, "R6", $sformatf("%s exact bin %0d im", req, k), yi[k], ei);
         end else begin
            chk((yr[k] - er <= TOL) && (er - yr[k] <= TOL), req,
                $sformatf("bin %0d re", k), yr[k], er);
            chk((yi[k] - ei <= TOL) && (ei - yi[k] <= TOL), req,
                $sformatf("bin %0d im", k), yi[k], ei);
         end
      end
   endtask

   // One isolated frame with R3 window and R9 latency checks.
   task automatic run_single(input string req, input bit gaps, input bit junk);
      int acc_cyc, first_cyc;
      send_frame(fa_re, fa_im, gaps, acc_cyc);
      for (int w = 1; w <= 6; w++) begin
         @(negedge clk);
         chk(in_ready == (w == 6), "R3", $sformatf("in_ready %0d cycles after frame", w),
             int'(in_ready), int'(w == 6));
         in_valid = junk && (w < 6);
         in_re    = DW'(next_rand());
         in_im    = DW'(next_rand());
      end
      collect(ya_re, ya_im, first_cyc);
      // six edges after the taking edge, seen at the following negedge
      chk(first_cyc - acc_cyc == 7, "R9", "edges from last sample to first bin",
          first_cyc - acc_cyc, 7);
      check_bins(fa_re, fa_im, ya_re, ya_im, req);
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R1", "in_ready after release", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R1", "out_valid after release", int'(out_valid), 0);
   endtask

   task automatic t_impulse();
      for (int n = 0; n < 16; n++) begin
         fa_re[n] = (n == 0) ? 1000 : 0;
         fa_im[n] = 0;
      end
      run_single("R4", 1'b0, 1'b0);
   endtask

   task automatic t_random();
      fill_random(fa_re, fa_im);
      run_single("R4", 1'b0, 1'b0);
   endtask

   task automatic t_gaps();
      fill_random(fa_re, fa_im);
      run_single("R2", 1'b1, 1'b0);
   endtask

   task automatic t_junk_while_busy();
      fill_random(fa_re, fa_im);
      run_single("R7", 1'b0, 1'b1);
      // the next frame must start cleanly at sample 0
      fill_random(fa_re, fa_im);
      run_single("R7", 1'b0, 1'b0);
   endtask

   task automatic t_full_scale();
      for (int n = 0; n < 16; n++) begin
         fa_re[n] = -2048;
         fa_im[n] = -2048;
      end
      run_single("R8", 1'b0, 1'b0);
      for (int n = 0; n < 16; n++) begin
         real th = 2.0 * 3.14159265358979323846 * real'(3 * n) / 16.0;
         fa_re[n] = rnd(2047.0 * $cos(th));
         fa_im[n] = rnd(2047.0 * $sin(th));
      end
      run_single("R8", 1'b0, 1'b0);
      for (int n = 0; n < 16; n++) begin
         fa_re[n] = (n % 2 == 0) ? 2047 : -2048;
         fa_im[n] = (n % 2 == 0) ? -2048 : 2047;
      end
      run_single("R8", 1'b0, 1'b0);
   endtask

   task automatic t_back_to_back();
      int ca, cb, fa_c, fb_c;
      fill_random(fa_re, fa_im);
      fill_random(fb_re, fb_im);
      fork
         begin
            send_frame(fa_re, fa_im, 1'b0, ca);
            send_frame(fb_re, fb_im, 1'b0, cb);
            @(negedge clk);
            in_valid = 1'b0;
         end
         begin
            collect(ya_re, ya_im, fa_c);
            collect(yb_re, yb_im, fb_c);
         end
      join
      chk(fa_c - ca == 7, "R10", "first frame latency", fa_c - ca, 7);
      chk(fb_c - cb == 7, "R10", "second frame latency", fb_c - cb, 7);
      check_bins(fa_re, fa_im, ya_re, ya_im, "R10");
      check_bins(fb_re, fb_im, yb_re, yb_im, "R10");
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_impulse();
      t_random();
      t_random();
      t_gaps();
      t_junk_while_busy();
      t_full_scale();
      t_back_to_back();
      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule